// File: doc/BRIEF.md
# Light-Level Window Alarm with Persistence Filter

This block watches a stream of light-sensor conversion results and raises an alarm when the light level stays outside a programmed window. Each result arrives with a one-cycle valid strobe. The block compares the most significant byte of the result against an 8-bit upper bound and an 8-bit lower bound. A result outside the window extends a run of consecutive out-of-window integration cycles. A result inside the window ends that run.

The alarm rises only when the run reaches the length chosen by a 2-bit persistence selector. This keeps short disturbances, such as a photographic flash, from triggering an interrupt. Once the alarm is raised, it stays latched until the host issues a clear request. The output models an active-low open-drain pin: it only ever pulls the line low, through an enable signal, and is otherwise released.

Top module: `lux_window_alarm`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `irq_flag` and `irq_pull_en` are both 0.
- R2: A valid result is out of window when its upper byte (`res_data[15:8]`) is strictly greater than `thr_hi` or strictly less than `thr_lo`. A result equal to either bound is inside the window.
- R3: The lower byte `res_data[7:0]` has no effect on the window decision.
- R4: `persist_sel` encodes the required run length: 2'b00 means 1, 2'b01 means 4, 2'b10 means 8 and 2'b11 means 16 consecutive out-of-window results.
- R5: `irq_flag` becomes 1 on the clock edge that registers the out-of-window result completing the required run. It is visible in the cycle after the strobe, and it never rises without such a result.
- R6: A valid in-window result resets the run to zero. A run that is one short of the required length and is then broken does not raise the flag.
- R7: Cycles with `res_valid` low leave both the run and the flag unchanged.
- R8: Once set, `irq_flag` stays 1 through any further results, whether in or out of window, until `irq_clear` is asserted.
- R9: `irq_clear` drops the flag and zeroes the run on the next edge. It takes priority over a result strobed in the same cycle, so a complete new run is needed before the flag rises again.
- R10: The pin model never drives high. `irq_pull_en` (1 = pull the line low, 0 = high impedance) always equals `irq_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe marking a completed conversion |
| res_data | input | 16 | Conversion result |
| thr_hi | input | 8 | Upper window bound, compared with the result's upper byte |
| thr_lo | input | 8 | Lower window bound, compared with the result's upper byte |
| persist_sel | input | 2 | Run-length selector (1/4/8/16 results) |
| irq_clear | input | 1 | Clears the latched alarm and the run |
| irq_flag | output | 1 | Latched alarm, active high |
| irq_pull_en | output | 1 | Open-drain enable: 1 pulls the interrupt line low |

## Verification
The hardest state to reach from the ports is a run that sits exactly one result short of the longest setting. From there, the next result either completes the run or breaks it. Reaching it takes fifteen consecutive out-of-window strobes, interleaved with idle cycles to show that gaps do not break the run. The stimulus then completes the run to confirm the flag rises on the sixteenth result. A separate four-result run is broken at its last step to show that the flag stays low. A clear issued in the same cycle as an out-of-window strobe shows that the clear wins, and the shortest setting then needs a fresh result.

// File: rtl/lwa_pkg.sv
`timescale 1ns/1ps
// Shared constants and the encoding of the persistence selector.
package lwa_pkg;
    typedef enum logic [1:0] {
        RUN_1  = 2'b00,
        RUN_4  = 2'b01,
        RUN_8  = 2'b10,
        RUN_16 = 2'b11
    } run_sel_e;

    localparam int unsigned MAX_RUN = 16;
    localparam int unsigned RUN_W   = $clog2(MAX_RUN + 1);
endpackage

// File: rtl/lwa_run_decode.sv
`timescale 1ns/1ps
// Converts the 2-bit persistence selector into the run length that must be reached.
// Assumes the run counter is RUN_W bits wide and can hold the largest length.
module lwa_run_decode
    import lwa_pkg::*;
#(
    parameter int unsigned W = RUN_W
) (
    input  logic [1:0]   sel,
    output logic [W-1:0] need
);
    // Map each encoding to its number of consecutive results.
    always_comb begin
        unique case (run_sel_e'(sel))
            RUN_1:   need = W'(1);
            RUN_4:   need = W'(4);
            RUN_8:   need = W'(8);
            default: need = W'(16);
        endcase
    end
endmodule

// File: rtl/lwa_window_cmp.sv
`timescale 1ns/1ps
// Decides whether a result lies outside the window.
// Only the top THR_W bits of the result are compared; the bounds are inclusive.
module lwa_window_cmp #(
    parameter int unsigned RES_W = 16,
    parameter int unsigned THR_W = 8
) (
    input  logic [RES_W-1:0] res,
    input  logic [THR_W-1:0] thr_hi,
    input  logic [THR_W-1:0] thr_lo,
    output logic             out_of_win
);
    localparam int unsigned LSB = RES_W - THR_W;

    logic [THR_W-1:0] level;
    logic             above;
    logic             below;

    // Pick the upper part of the result as the compared light level.
    always_comb level = res[RES_W-1:LSB];

    // Strict comparisons: a level equal to a bound is still inside the window.
    always_comb begin
        above      = level > thr_hi;
        below      = level < thr_lo;
        out_of_win = above | below;
    end
endmodule

// File: rtl/lwa_run_latch.sv
`timescale 1ns/1ps
// Counts consecutive out-of-window results and latches the alarm when the run
// reaches the required length. Assumes need is between 1 and MAX_RUN.
module lwa_run_latch
    import lwa_pkg::*;
#(
    parameter int unsigned LIMIT = MAX_RUN,
    parameter int unsigned W     = RUN_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid,
    input  logic         out_of_win,
    input  logic         clear,
    input  logic [W-1:0] need,
    output logic         flag,
    output logic [W-1:0] run
);
    logic [W-1:0] run_inc;

    // Saturating increment so the counter never wraps while the alarm is latched.
    always_comb run_inc = (run == W'(LIMIT)) ? run : run + W'(1);

    // Run counter: clear wins, an in-window result resets, an out-of-window one extends.
    always_ff @(posedge clk) begin
        if (!rst_n)          run <= '0;
        else if (clear)      run <= '0;
        else if (valid)      run <= out_of_win ? run_inc : '0;
    end

    // Alarm latch: set when the run completes, held until a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    flag <= 1'b0;
        else if (clear)                                flag <= 1'b0;
        else if (valid && out_of_win && run_inc >= need) flag <= 1'b1;
    end

    p_run_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run <= W'(LIMIT));
    p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(valid && out_of_win));
    p_inwin_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !out_of_win && !clear) |=> (run == '0));
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !clear) |=> ($stable(run) && $stable(flag)));
    p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clear) |=> flag);
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!flag && run == '0));
endmodule

// File: rtl/lux_window_alarm.sv
`timescale 1ns/1ps
// Window alarm with persistence filter. Compares each strobed result against
// two byte-wide bounds, requires a selectable run of out-of-window results and
// drives an open-drain style enable that only ever pulls the interrupt line low.
module lux_window_alarm
    import lwa_pkg::*;
#(
    parameter int unsigned RES_W = 16,
    parameter int unsigned THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    input  logic [THR_W-1:0] thr_hi,
    input  logic [THR_W-1:0] thr_lo,
    input  logic [1:0]       persist_sel,
    input  logic             irq_clear,
    output logic             irq_flag,
    output logic             irq_pull_en
);
    logic             outside;
    logic [RUN_W-1:0] need;
    logic [RUN_W-1:0] run;

    lwa_window_cmp #(.RES_W(RES_W), .THR_W(THR_W)) u_cmp (
        .res        (res_data),
        .thr_hi     (thr_hi),
        .thr_lo     (thr_lo),
        .out_of_win (outside)
    );

    lwa_run_decode #(.W(RUN_W)) u_dec (
        .sel  (persist_sel),
        .need (need)
    );

    lwa_run_latch #(.LIMIT(MAX_RUN), .W(RUN_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (res_valid),
        .out_of_win (outside),
        .clear      (irq_clear),
        .need       (need),
        .flag       (irq_flag),
        .run        (run)
    );

    // Pin model: pull low while the alarm is latched, release otherwise.
    assign irq_pull_en = irq_flag;

    p_run_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag == 1'b0) |-> (run < need || run == '0 || !$past(res_valid)));
endmodule

// File: tb/lux_window_alarm_bench.sv
`timescale 1ns/1ps
module lux_window_alarm_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  flag;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic [7:0]  thr_hi = 8'h80;
    logic [7:0]  thr_lo = 8'h20;
    logic [1:0]  persist_sel = 2'b00;
    logic        irq_clear = 1'b0;
    logic        irq_flag;
    logic        irq_pull_en;

    int   n_run = 0;
    int   n_fail = 0;
    exp_t sb[$];
    int   m_run = 0;
    logic m_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lux_window_alarm u_lux_window_alarm (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .persist_sel(persist_sel),
        .irq_clear(irq_clear), .irq_flag(irq_flag), .irq_pull_en(irq_pull_en)
    );

    function automatic int need_of(logic [1:0] s);
        case (s)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 16;
        endcase
    endfunction

    // Driver: apply one cycle of stimulus and push the expected outcome.
    task automatic step(input logic v, input logic [15:0] d, input logic c, input string req);
        logic o;
        @(negedge clk);
        res_valid = v; res_data = d; irq_clear = c;
        o = (d[15:8] > thr_hi) || (d[15:8] < thr_lo);
        if (c) begin
            m_run = 0; m_flag = 1'b0;
        end else if (v) begin
            if (o) begin
                if (m_run < 16) m_run++;
                if (m_run >= need_of(persist_sel)) m_flag = 1'b1;
            end else m_run = 0;
        end
        sb.push_back('{flag: m_flag, req: req});
    endtask

    task automatic idle(input string req);
        step(1'b0, 16'h0000, 1'b0, req);
    endtask

    // Monitor: after each edge, compare outputs with the oldest expected item.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                n_run++;
                if (irq_flag !== e.flag) begin
                    n_fail++;
                    $display("FAIL %s irq_flag actual=%b expected=%b", e.req, irq_flag, e.flag);
                end
                if (irq_pull_en !== e.flag) begin
                    n_fail++;
                    $display("FAIL R10 irq_pull_en actual=%b expected=%b", irq_pull_en, e.flag);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: out-of-window strobes while in reset must not set anything.
        res_valid = 1'b1; res_data = 16'hFF00;
        repeat (3) @(posedge clk);
        #1;
        n_run++;
        if (irq_flag !== 1'b0 || irq_pull_en !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset outputs actual=%b%b expected=00", irq_flag, irq_pull_en);
        end
        @(negedge clk);
        res_valid = 1'b0;
        rst_n = 1'b1;
        idle("R1");

        // R2 / R3: bounds are inclusive, lower byte ignored, single-result setting.
        persist_sel = 2'b00;
        step(1'b1, 16'h8000, 1'b0, "R2");
        step(1'b1, 16'h2000, 1'b0, "R2");
        step(1'b1, 16'h80FF, 1'b0, "R3");
        step(1'b1, 16'h20FF, 1'b0, "R3");
        step(1'b1, 16'h1FFF, 1'b0, "R2");
        step(1'b0, 16'h0, 1'b1, "R9");
        step(1'b1, 16'h8100, 1'b0, "R2");
        step(1'b0, 16'h0, 1'b1, "R9");

        // R4 / R6: four-result setting, run broken one short.
        persist_sel = 2'b01;
        for (int i = 0; i < 3; i++) step(1'b1, 16'hF000, 1'b0, "R6");
        step(1'b1, 16'h5000, 1'b0, "R6");
        for (int i = 0; i < 3; i++) step(1'b1, 16'h0500, 1'b0, "R4");
        // R7: idle gaps keep the run.
        idle("R7"); idle("R7");
        step(1'b1, 16'h0500, 1'b0, "R5");
        // R8: latched through in- and out-of-window results.
        step(1'b1, 16'h5000, 1'b0, "R8");
        idle("R8");
        step(1'b1, 16'hFF00, 1'b0, "R8");

        // R9: clear beats a simultaneous out-of-window result.
        persist_sel = 2'b00;
        step(1'b1, 16'hFF00, 1'b1, "R9");
        idle("R9");
        step(1'b1, 16'hFF00, 1'b0, "R9");
        step(1'b0, 16'h0, 1'b1, "R9");

        // R4: eight-result setting.
        persist_sel = 2'b10;
        for (int i = 0; i < 7; i++) step(1'b1, 16'hFF00, 1'b0, "R4");
        step(1'b1, 16'hFF00, 1'b0, "R4");
        step(1'b0, 16'h0, 1'b1, "R9");

        // R4 / R7: sixteen-result setting with gaps, completed at the last result.
        persist_sel = 2'b11;
        for (int i = 0; i < 15; i++) begin
            step(1'b1, 16'h0000, 1'b0, "R4");
            if (i % 4 == 1) idle("R7");
        end
        step(1'b1, 16'h0000, 1'b0, "R4");
        idle("R8");
        step(1'b0, 16'h0, 1'b1, "R9");
        idle("R9");

        @(negedge clk); @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule